// File: doc/BRIEF.md
# Chained Lifetime Down-Counter Timer

Two reloadable down-counters share one clock. The first channel counts down by one on every clock while enabled. When it sits at zero it reloads from its load value on the next tick. With chaining switched on, the second channel takes one step each time the first channel reloads. The two channels then form a 64-bit lifetime counter: the second channel is the upper half and the first is the lower half. With chaining off, the second channel runs on its own clock like the first.

Software reaches the block through a small register window. It has a write strobe and a read strobe with separate addresses. Read data is combinational in the cycle the read strobe is high. A read of the upper lifetime word returns the live upper count. The same read captures the live lower count into a shadow register at that clock edge, and the next lower-word read returns the shadow. Because the second channel steps at the very edge where the first reloads, the captured pair always belongs to one instant. When the lower word equals the first channel's load value, the upper word already holds the stepped count. Each channel has a timeout flag, driven to a pin, that sets on every reload and is cleared by writing one.

Top module: `lifetime_timer`

## Requirements
- R1: After reset every register reads zero: both load values, both current counts, control, flags, the upper and the lower lifetime words. Both `tmo_o` bits are low.
- R2: A channel starts when its enable bit goes from 0 to 1. On the first clock edge where the enable register is already 1, the current count is loaded from the load value. After that it steps down by one per tick. On the tick at zero it reloads, so one period is load+1 ticks.
- R3: When the chain bit is set, channel 1 ticks only at the clock edge where channel 0 reloads, in that same edge and never one edge later. Between those edges channel 1 holds its value. A channel 0 load value of zero makes channel 1 tick on every edge.
- R4: When the chain bit is clear, channel 1 ticks on every clock, independently of channel 0.
- R5: Writing a load value while the channel runs does not change its current count. The new value is used at the channel's next reload.
- R6: A disabled channel holds its current count. A load value written while the channel is disabled is taken when the channel is next enabled.
- R7: Flag bit n (bit 0 for channel 0, bit 1 for channel 1) sets at every reload of channel n and also drives `tmo_o[n]`. Writing 1 to a flag bit at address 3 clears it. If a reload and a clear happen in the same edge, the flag stays set.
- R8: A read of address 6 returns channel 1's live count. At that same edge, channel 0's live count is captured into a shadow register. A read of address 7 returns the shadow, so the pair read back belongs to one clock instant.
- R9: The shadow changes only on a read of address 6. Repeated reads of address 7 return the same value, which is zero before the first read of address 6.
- R10: Register map: 0 holds the channel 0 load value and 1 the channel 1 load value. Address 2 is control: bit 0 enables channel 0, bit 1 enables channel 1 and bit 2 turns on chaining. Address 3 holds the flags, 4 channel 0's current count, 5 channel 1's current count, 6 the upper lifetime word and 7 the lower lifetime word. Unused bits read zero. `rd_data` is zero when `rd_en` is low.
- R11: Writes to addresses 4 to 7 are ignored, and writing 0 to a flag bit leaves that bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | CNT_W | Write data |
| rd_en | input | 1 | Register read strobe; an upper-word read also captures the lower word |
| rd_addr | input | 3 | Read address |
| rd_data | output | CNT_W | Combinational read data |
| tmo_o | output | 2 | Timeout flags, one per channel |

## Verification
The bench builds the block with CNT_W = 16 and uses load values of 0 to 5. With these values both channels pass through zero and reload many times within a few dozen cycles. In chained mode the upper channel also wraps, so the upper-word read meets the exact edge where the lower word shows its load value and the upper word has just stepped. The upper/lower read pair is issued at many phases of the lower count, and flag clears are issued on every cycle so that they land on reload edges.

// File: rtl/lt_pkg.sv
package lt_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_LOAD0   = 3'd0,
    A_LOAD1   = 3'd1,
    A_CTRL    = 3'd2,
    A_FLAGS   = 3'd3,
    A_CUR0    = 3'd4,
    A_CUR1    = 3'd5,
    A_LIFE_HI = 3'd6,
    A_LIFE_LO = 3'd7
  } reg_addr_e;

  localparam int CTRL_EN0   = 0;
  localparam int CTRL_EN1   = 1;
  localparam int CTRL_CHAIN = 2;
  localparam int CTRL_W     = 3;
endpackage

// File: rtl/lt_chan.sv
module lt_chan #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] load_i,
  output logic [CNT_W-1:0] cur_o,
  output logic             reload_o
);
  logic [CNT_W-1:0] cur_q;
  logic             run_q;
  logic             start, active, at_zero;

  assign start    = en_i & ~run_q;
  assign active   = en_i & run_q;
  assign at_zero  = (cur_q == '0);
  assign reload_o = active & tick_i & at_zero;
  assign cur_o    = cur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      run_q <= 1'b0;
    end else begin
      run_q <= en_i;
      if (start) begin
        cur_q <= load_i;
      end else if (active && tick_i) begin
        cur_q <= at_zero ? load_i : cur_q - 1'b1;
      end
    end
  end

  // R6: a disabled channel keeps its count
  a_r6_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(cur_o));

  // R2: a running channel not at zero moves down by exactly one per tick
  a_r2_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && run_q && tick_i && cur_o != '0) |=> (cur_o == $past(cur_o) - 1'b1));

  // R3: with no tick a running channel holds
  a_r3_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && run_q && !tick_i) |=> $stable(cur_o));
endmodule

// File: rtl/lt_readout.sv
module lt_readout
  import lt_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int NCH   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [CNT_W-1:0]  cur0_i,
  input  logic [CNT_W-1:0]  cur1_i,
  input  logic [CNT_W-1:0]  load0_i,
  input  logic [CNT_W-1:0]  load1_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [NCH-1:0]    flag_i,
  output logic [CNT_W-1:0]  rd_data
);
  logic [CNT_W-1:0] shadow_q;
  logic             hi_rd;

  assign hi_rd = rd_en && (rd_addr == A_LIFE_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shadow_q <= '0;
    else if (hi_rd) shadow_q <= cur0_i;
  end

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      case (rd_addr)
        A_LOAD0:   rd_data = load0_i;
        A_LOAD1:   rd_data = load1_i;
        A_CTRL:    rd_data[CTRL_W-1:0] = ctrl_i;
        A_FLAGS:   rd_data[NCH-1:0] = flag_i;
        A_CUR0:    rd_data = cur0_i;
        A_CUR1:    rd_data = cur1_i;
        A_LIFE_HI: rd_data = cur1_i;
        A_LIFE_LO: rd_data = shadow_q;
        default:   rd_data = '0;
      endcase
    end
  end

  // R8: the upper read captures the lower count seen in that cycle
  a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
    hi_rd |=> (shadow_q == $past(cur0_i)));

  // R9: the shadow only moves on an upper-word read
  a_r9_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_rd |=> $stable(shadow_q));
endmodule

// File: rtl/lifetime_timer.sv
module lifetime_timer
  import lt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic [1:0]        tmo_o
);
  localparam int NCH = 2;

  logic [CNT_W-1:0] load_q [NCH];
  logic [CNT_W-1:0] cur_w  [NCH];
  logic [NCH-1:0]   ch_en_q;
  logic             chain_q;
  logic [NCH-1:0]   flag_q;
  logic [NCH-1:0]   rld;
  logic [NCH-1:0]   tick;
  logic [NCH-1:0]   flag_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) load_q[i] <= '0;
      ch_en_q <= '0;
      chain_q <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        A_LOAD0: load_q[0] <= wr_data;
        A_LOAD1: load_q[1] <= wr_data;
        A_CTRL: begin
          ch_en_q[0] <= wr_data[CTRL_EN0];
          ch_en_q[1] <= wr_data[CTRL_EN1];
          chain_q    <= wr_data[CTRL_CHAIN];
        end
        default: ;
      endcase
    end
  end

  assign flag_clr = (wr_en && wr_addr == A_FLAGS) ? wr_data[NCH-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~flag_clr) | rld;
  end

  assign tmo_o = flag_q;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    if (g == 0) begin : g_head
      assign tick[g] = 1'b1;
    end else begin : g_link
      assign tick[g] = chain_q ? rld[g-1] : 1'b1;
    end

    lt_chan #(.CNT_W(CNT_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (ch_en_q[g]),
      .tick_i   (tick[g]),
      .load_i   (load_q[g]),
      .cur_o    (cur_w[g]),
      .reload_o (rld[g])
    );

    // R7: every reload leaves its flag set
    a_r7_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
      rld[g] |=> flag_q[g]);
  end

  lt_readout #(.CNT_W(CNT_W), .NCH(NCH)) u_readout (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .cur0_i  (cur_w[0]),
    .cur1_i  (cur_w[1]),
    .load0_i (load_q[0]),
    .load1_i (load_q[1]),
    .ctrl_i  ({chain_q, ch_en_q[1], ch_en_q[0]}),
    .flag_i  (flag_q),
    .rd_data (rd_data)
  );

  // R3: the upper channel steps at the same edge as the lower reload
  a_r3_one_per_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_q && ch_en_q[1] && $past(ch_en_q[1]) && rld[0] && cur_w[1] != '0)
      |=> (cur_w[1] == $past(cur_w[1]) - 1'b1));

  // R3: without a lower reload the chained upper channel holds
  a_r3_hold_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_q && ch_en_q[1] && $past(ch_en_q[1]) && !rld[0]) |=> $stable(cur_w[1]));
endmodule

// File: tb/lifetime_timer_bench.sv
module lifetime_timer_bench;
  localparam int W = 16;
  localparam logic [2:0] AL0 = 3'd0, AL1 = 3'd1, ACT = 3'd2, AFL = 3'd3,
                         AC0 = 3'd4, AC1 = 3'd5, AHI = 3'd6, ALO = 3'd7;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic         rd_en = 1'b0;
  logic [2:0]   rd_addr = '0;
  logic [W-1:0] rd_data;
  logic [1:0]   tmo_o;

  int checks = 0;
  int failures = 0;

  // reference model state
  logic [W-1:0] m_load [2];
  logic [W-1:0] m_cur  [2];
  bit           m_en   [2];
  bit           m_pe   [2];
  bit           m_chain;
  logic [1:0]   m_flag;
  logic [W-1:0] m_shadow;

  always #5 clk = ~clk;

  lifetime_timer #(.CNT_W(W)) u_lifetime_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .tmo_o(tmo_o)
  );

  function automatic logic [W-1:0] exp_rd(input bit re, input logic [2:0] ra);
    logic [W-1:0] v = '0;
    if (re) begin
      case (ra)
        AL0: v = m_load[0];
        AL1: v = m_load[1];
        ACT: v[2:0] = {m_chain, m_en[1], m_en[0]};
        AFL: v[1:0] = m_flag;
        AC0: v = m_cur[0];
        AC1: v = m_cur[1];
        AHI: v = m_cur[1];
        default: v = m_shadow;
      endcase
    end
    return v;
  endfunction

  task automatic model_step(input bit we, input logic [2:0] wa, input logic [W-1:0] wd,
                            input bit re, input logic [2:0] ra);
    logic [W-1:0] nx [2];
    bit rl [2];
    bit tk;
    for (int c = 0; c < 2; c++) begin
      nx[c] = m_cur[c];
      rl[c] = 1'b0;
      tk = (c == 0) ? 1'b1 : (m_chain ? rl[0] : 1'b1);
      if (m_en[c] && !m_pe[c]) nx[c] = m_load[c];
      else if (m_en[c] && tk) begin
        if (m_cur[c] == 0) begin nx[c] = m_load[c]; rl[c] = 1'b1; end
        else nx[c] = m_cur[c] - 1;
      end
    end
    if (re && ra == AHI) m_shadow = m_cur[0];
    if (we && wa == AFL) m_flag = m_flag & ~wd[1:0];
    m_flag = m_flag | {rl[1], rl[0]};
    m_pe[0] = m_en[0];
    m_pe[1] = m_en[1];
    if (we) begin
      case (wa)
        AL0: m_load[0] = wd;
        AL1: m_load[1] = wd;
        ACT: begin m_en[0] = wd[0]; m_en[1] = wd[1]; m_chain = wd[2]; end
        default: ;
      endcase
    end
    m_cur[0] = nx[0];
    m_cur[1] = nx[1];
  endtask

  task automatic check(input string tag, input string what, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit we, input logic [2:0] wa, input logic [W-1:0] wd,
                     input bit re, input logic [2:0] ra, input string tag);
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
    #1;
    check(tag, "rd_data", rd_data, exp_rd(re, ra));
    check(tag, "tmo_o", {{(W-2){1'b0}}, tmo_o}, {{(W-2){1'b0}}, m_flag});
    @(posedge clk);
    #1;
    model_step(we, wa, wd, re, ra);
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 3'd0, '0, 1'b1, (i % 2 == 0) ? AC0 : AC1, tag);
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d, input string tag);
    cyc(1'b1, a, d, 1'b1, AC0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int c = 0; c < 2; c++) begin
      m_load[c] = '0; m_cur[c] = '0; m_en[c] = 1'b0; m_pe[c] = 1'b0;
    end
    m_chain = 1'b0; m_flag = '0; m_shadow = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset contents, R9 lower word before any upper read
    for (int a = 0; a < 8; a++) cyc(1'b0, 3'd0, '0, 1'b1, 3'(a), "R1");
    cyc(1'b0, 3'd0, '0, 1'b1, ALO, "R9");
    // R10 map and read-back, zero when not reading
    wr(AL0, 16'd5, "R10");
    wr(AL1, 16'd3, "R10");
    cyc(1'b0, 3'd0, '0, 1'b1, AL0, "R10");
    cyc(1'b0, 3'd0, '0, 1'b1, AL1, "R10");
    cyc(1'b0, 3'd0, '0, 1'b0, AL0, "R10");
    // R2 channel 0 alone
    wr(ACT, 16'h1, "R2");
    cyc(1'b0, 3'd0, '0, 1'b1, ACT, "R10");
    run(16, "R2");
    // R11 zero write to flags, R7 clear and set-wins
    cyc(1'b1, AFL, 16'h0, 1'b1, AFL, "R11");
    for (int i = 0; i < 14; i++) cyc(1'b1, AFL, 16'h3, 1'b1, AFL, "R7");
    // R5 load change while running
    wr(AL0, 16'd2, "R5");
    run(12, "R5");
    // R6 disable, reload value while off, re-enable
    wr(ACT, 16'h0, "R6");
    run(6, "R6");
    wr(AL0, 16'd4, "R6");
    run(3, "R6");
    wr(ACT, 16'h1, "R6");
    run(10, "R2");
    // R4 independent channel 1
    wr(AL1, 16'd2, "R4");
    wr(ACT, 16'h3, "R4");
    run(14, "R4");
    // R3 chained, upper wraps
    wr(ACT, 16'h0, "R3");
    wr(AL0, 16'd3, "R3");
    wr(AL1, 16'd2, "R3");
    wr(ACT, 16'h7, "R3");
    run(40, "R3");
    // R8 coherent pair at many phases
    for (int k = 0; k < 14; k++) begin
      cyc(1'b0, 3'd0, '0, 1'b1, AHI, "R8");
      if (k % 3 == 1) run(1, "R8");
      cyc(1'b0, 3'd0, '0, 1'b1, ALO, "R8");
      // R9 repeated lower read keeps the capture
      cyc(1'b0, 3'd0, '0, 1'b1, ALO, "R9");
    end
    // R11 writes to read-only addresses
    cyc(1'b1, AC0, 16'hBEEF, 1'b1, AC1, "R11");
    cyc(1'b1, AC1, 16'h1234, 1'b1, AC0, "R11");
    cyc(1'b1, AHI, 16'h5555, 1'b1, AC1, "R11");
    cyc(1'b1, ALO, 16'hAAAA, 1'b1, ALO, "R11");
    // R3 lower load zero: upper steps every edge
    wr(ACT, 16'h0, "R3");
    wr(AL0, 16'd0, "R3");
    wr(AL1, 16'd5, "R3");
    wr(ACT, 16'h7, "R3");
    run(14, "R3");
    cyc(1'b0, 3'd0, '0, 1'b1, AHI, "R8");
    cyc(1'b0, 3'd0, '0, 1'b1, ALO, "R8");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule